// File: doc/BRIEF.md
# Fan PWM Generator with Rise and Fall Points

This block drives one fan-control PWM pin. The input clock first passes through a two-stage prescaler. One stage divides by a power of two. The second stage divides by one, or by an even number. Each prescaled tick advances a position counter that runs from 0 up to a programmable unit value and then wraps. The unit value therefore sets the period at unit + 1 positions.

The waveform is set by two positions. The pin goes high when the counter reaches the rise position and low when it reaches the fall position. Equal rise and fall positions give a constant high output. Software uses 0/0 when the requested on-time fills the whole period. Clearing the enable input forces the pin low and parks every counter at zero, so each enable starts a fresh period.

Rise, fall and unit are held in shadow registers. While the block is disabled the shadows follow the inputs. While it runs they reload only when the period wraps, so a mid-period update never produces a truncated or doubled pulse.

Top module: `pwm_fan_gen`

## Requirements
- R1: While rst_ni is low, pwm_o is 0 and all counters and shadow registers are zero.
- R2: The power-of-two stage divides the clock by 2^div_hi_i.
- R3: The second prescaler stage divides by 1 when div_lo_i is 0 and by 2*div_lo_i otherwise. One position therefore lasts D = 2^div_hi_i * (div_lo_i==0 ? 1 : 2*div_lo_i) clock cycles.
- R4: The position counter runs 0..unit and then wraps to 0, so the waveform repeats every D*(unit+1) cycles. With unit 0 the counter stays at 0.
- R5: With rise < fall, pwm_o is high at positions p where rise <= p < fall and low elsewhere. A point above unit is never reached.
- R6: With rise > fall, the high window wraps around the period end: pwm_o is high where p >= rise or p < fall.
- R7: With rise == fall, including 0/0, pwm_o is high for the whole period.
- R8: While en_i is low, pwm_o is 0 from the following cycle and the counters are held at 0. Counting restarts when en_i rises. pwm_o after the j-th edge at which en_i is sampled high, counting from 0, shows the level of position floor(j/D) mod (unit+1).
- R9: While enabled, new rise, fall and unit values take effect only from the first position 0 after the period wraps. While disabled, the shadows follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low forces pwm_o low and clears counters |
| div_hi_i | input | HI_W (3) | Power-of-two prescaler exponent |
| div_lo_i | input | LO_W (4) | Even prescaler field (0 means divide by 1) |
| unit_i | input | 8 | Last counter position of a period |
| rise_i | input | 8 | Position at which the output goes high |
| fall_i | input | 8 | Position at which the output goes low |
| pwm_o | output | 1 | PWM output |

## Verification
Two things can happen on the same edge: the period wrap and the reload of new rise and fall values. A changed set of points could therefore leak into the last position of the old period or into the whole current one. The bench changes the points two positions into a period. It then checks that every remaining position of that period still follows the old window and that position 0 of the next period follows the new one. A separate case drops en_i for a single cycle in the middle of a period and then expects the pattern to start again from position 0.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int PT_W     = 8;
  localparam int HI_W_DEF = 3;
  localparam int LO_W_DEF = 4;

  typedef struct packed {
    logic [PT_W-1:0] rise;
    logic [PT_W-1:0] fall;
    logic [PT_W-1:0] unit;
  } pts_t;

  function automatic logic in_window(logic [PT_W-1:0] p, logic [PT_W-1:0] r,
                                     logic [PT_W-1:0] f);
    if (r == f)     return 1'b1;
    else if (r < f) return (p >= r) && (p < f);
    else            return (p >= r) || (p < f);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int HI_W = 3,
  parameter int LO_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [HI_W-1:0] div_hi_i,
  input  logic [LO_W-1:0] div_lo_i,
  output logic            tick_o
);
  localparam int HI_CNT_W = (1 << HI_W) - 1;
  localparam int LO_CNT_W = LO_W + 1;

  logic [HI_CNT_W-1:0] hi_cnt;
  logic [HI_CNT_W:0]   hi_span, hi_lim;
  logic [LO_CNT_W-1:0] lo_cnt, lo_lim;
  logic                hi_last, lo_last;

  assign hi_span = (HI_CNT_W+1)'(1) << div_hi_i;
  assign hi_lim  = hi_span - (HI_CNT_W+1)'(1);
  assign hi_last = ({1'b0, hi_cnt} == hi_lim);

  // field 0 -> /1, else /(2*field)
  assign lo_lim  = (div_lo_i == '0) ? '0 : ({div_lo_i, 1'b0} - LO_CNT_W'(1));
  assign lo_last = (lo_cnt == lo_lim);

  assign tick_o  = run_i & hi_last & lo_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (!run_i) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (hi_last) begin
      hi_cnt <= '0;
      lo_cnt <= lo_last ? '0 : lo_cnt + LO_CNT_W'(1);
    end else begin
      hi_cnt <= hi_cnt + HI_CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_gen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  input  pts_t            pts_i,
  output logic [PT_W-1:0] pos_o,
  output pts_t            shadow_o
);
  logic [PT_W-1:0] pos_q;
  pts_t            sh_q;
  logic            wrap;

  assign wrap     = tick_i && (pos_q == sh_q.unit);
  assign pos_o    = pos_q;
  assign shadow_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sh_q  <= '0;
    end else if (!run_i) begin
      pos_q <= '0;
      sh_q  <= pts_i;
    end else if (wrap) begin
      pos_q <= '0;
      sh_q  <= pts_i;   // reload only at period boundary
    end else if (tick_i) begin
      pos_q <= pos_q + PT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_gen_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PT_W-1:0] pos_i,
  input  pts_t            shadow_i,
  output logic            pwm_o
);
  logic lvl;

  assign lvl = in_window(pos_i, shadow_i.rise, shadow_i.fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_o <= 1'b0;
    else         pwm_o <= run_i & lvl;
  end
endmodule

// File: rtl/pwm_fan_gen.sv
module pwm_fan_gen
  import pwm_gen_pkg::*;
#(
  parameter int HI_W = HI_W_DEF,
  parameter int LO_W = LO_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [HI_W-1:0] div_hi_i,
  input  logic [LO_W-1:0] div_lo_i,
  input  logic [PT_W-1:0] unit_i,
  input  logic [PT_W-1:0] rise_i,
  input  logic [PT_W-1:0] fall_i,
  output logic            pwm_o
);
  logic            tick_w;
  logic [PT_W-1:0] pos_w;
  pts_t            pts_in, shadow_w;

  assign pts_in = '{rise: rise_i, fall: fall_i, unit: unit_i};

  pwm_prescaler #(.HI_W(HI_W), .LO_W(LO_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .div_hi_i (div_hi_i),
    .div_lo_i (div_lo_i),
    .tick_o   (tick_w)
  );

  pwm_period_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .tick_i   (tick_w),
    .pts_i    (pts_in),
    .pos_o    (pos_w),
    .shadow_o (shadow_w)
  );

  pwm_edge_gen u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_i),
    .pos_i    (pos_w),
    .shadow_i (shadow_w),
    .pwm_o    (pwm_o)
  );
endmodule

// File: rtl/pwm_fan_gen_chk.sv
module pwm_fan_gen_chk
  import pwm_gen_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            pwm_o,
  input logic            tick_i,
  input logic [PT_W-1:0] pos_i,
  input pts_t            shadow_i
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pwm_rst_low_chk: assert (!pwm_o);
    end
  end

  // R8
  pwm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  // R9
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(tick_i && pos_i == shadow_i.unit)) |=> $stable(shadow_i));

  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (pos_i <= shadow_i.unit));

  // R3
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(pos_i));

  // R7
  flat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && shadow_i.rise == shadow_i.fall) |=> pwm_o);
endmodule

bind pwm_fan_gen pwm_fan_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .pwm_o    (pwm_o),
  .tick_i   (tick_w),
  .pos_i    (pos_w),
  .shadow_i (shadow_w)
);

// File: tb/sim_pwm_fan_gen.sv
module sim_pwm_fan_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 3;
  localparam int LO_W = 4;

  typedef struct packed {
    logic [2:0] h;
    logic [3:0] l;
    logic [7:0] u;
    logic [7:0] r;
    logic [7:0] f;
  } vec_t;

  // h, l, unit, rise, fall
  localparam vec_t VEC [8] = '{
    '{3'd0, 4'd0, 8'd9, 8'd2, 8'd6},   // R5 plain window
    '{3'd1, 4'd0, 8'd4, 8'd0, 8'd3},   // R2
    '{3'd0, 4'd1, 8'd5, 8'd4, 8'd1},   // R6 wrapped window, R3
    '{3'd2, 4'd3, 8'd3, 8'd1, 8'd2},   // R2 R3 combined
    '{3'd0, 4'd0, 8'd7, 8'd0, 8'd0},   // R7 0/0
    '{3'd1, 4'd2, 8'd2, 8'd3, 8'd0},   // R5 rise beyond unit
    '{3'd0, 4'd0, 8'd0, 8'd0, 8'd5},   // R4 unit 0
    '{3'd3, 4'd0, 8'd2, 8'd2, 8'd2}    // R7 equal nonzero
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic [HI_W-1:0] div_hi_i = '0;
  logic [LO_W-1:0] div_lo_i = '0;
  logic [7:0]      unit_i = '0, rise_i = '0, fall_i = '0;
  logic            pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_fan_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_hi_i(div_hi_i),
    .div_lo_i(div_lo_i), .unit_i(unit_i), .rise_i(rise_i), .fall_i(fall_i),
    .pwm_o(pwm_o)
  );

  function automatic bit exp_lvl(int p, int r, int f);
    if (r == f) return 1'b1;
    if (r < f) return (p >= r) && (p < f);
    return (p >= r) || (p < f);
  endfunction

  function automatic int div_of(int h, int l);
    return (1 << h) * ((l == 0) ? 1 : 2 * l);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(int h, int l, int u, int r, int f);
    @(negedge clk_i);
    en_i = 1'b0;
    div_hi_i = HI_W'(h); div_lo_i = LO_W'(l);
    unit_i = 8'(u); rise_i = 8'(r); fall_i = 8'(f);
    @(negedge clk_i);
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic run_pattern(int h, int l, int u, int r, int f, int ncyc, string req);
    int d, bad, fa, fe;
    bit e;
    d = div_of(h, l); bad = 0; fa = 0; fe = 0;
    setup(h, l, u, r, f);
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk_i);
      e = exp_lvl((j / d) % (u + 1), r, f);
      if (pwm_o !== e) begin
        if (bad == 0) begin fa = int'(pwm_o); fe = int'(e); end
        bad++;
      end
    end
    check(bad == 0, req, fa, fe);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int bad, fa, fe, p;
    bit e;
    // R1: reset holds output low even with an always-high setting
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(pwm_o === 1'b0, "R1 reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check(pwm_o === 1'b1, "R7 zero points after reset", int'(pwm_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    check(pwm_o === 1'b0, "R8 disable forces low", int'(pwm_o), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      run_pattern(int'(VEC[i].h), int'(VEC[i].l), int'(VEC[i].u), int'(VEC[i].r),
                  int'(VEC[i].f),
                  2 * div_of(int'(VEC[i].h), int'(VEC[i].l)) * (int'(VEC[i].u) + 1),
                  "R2 R3 R4 R5 R6 R7 table");
    end

    // R2 R3: largest division
    run_pattern(7, 15, 1, 0, 1, 2 * 3840 * 2, "R2 R3 max division");

    // R9: points changed mid-period take effect at next position 0
    setup(0, 0, 3, 1, 3);
    bad = 0; fa = 0; fe = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk_i);
      p = j % 4;
      e = (j < 4) ? exp_lvl(p, 1, 3) : exp_lvl(p, 0, 1);
      if (pwm_o !== e) begin
        if (bad == 0) begin fa = int'(pwm_o); fe = int'(e); end
        bad++;
      end
      if (j == 1) begin rise_i = 8'd0; fall_i = 8'd1; end
    end
    check(bad == 0, "R9 shadow reload at wrap", fa, fe);

    // R8: one-cycle disable mid-period restarts from position 0
    run_pattern(0, 0, 3, 1, 3, 6, "R5 before restart");
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(pwm_o === 1'b0, "R8 short disable", int'(pwm_o), 0);
    en_i = 1'b1;
    bad = 0; fa = 0; fe = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk_i);
      e = exp_lvl(j % 4, 1, 3);
      if (pwm_o !== e) begin
        if (bad == 0) begin fa = int'(pwm_o); fe = int'(e); end
        bad++;
      end
    end
    check(bad == 0, "R8 restart from zero", fa, fe);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule